// File: doc/BRIEF.md
# Video Port Input Synchronizer

This block sits on the receive side of a byte-serial digital video port. It takes each byte with its data qualifier and two timing reference pins, horizontal and vertical. It hands a downstream scaler a qualified pixel stream, a one-cycle line-start marker, a one-cycle field-start marker and a field identifier. Everything runs in the port clock domain. The configuration is a set of static register bits that are driven straight into the block.

The timing can come from two places. In reference mode, the horizontal and vertical pins pass through a synchronizer chain, and the programmed edges of the synchronized levels raise the markers. In embedded mode, the block ignores the pins and looks for four-byte timing codes inside the qualified byte stream. A start-of-active-video code opens a line. A code that leaves vertical blanking starts a field. The field bit of each code gives the field identifier.

A source-select bit says whether this port feeds the scaler or the internal decoder does. When the port is not selected, the valid flag and the markers are held low.

Top module: `vport_sync`

## Requirements
- R1: `out_data` carries the input byte one clock after the byte is sampled. `out_valid` is high in that same cycle exactly when `in_qual` equals `cfg_qual_pol` (1 means the qualifier is active high, 0 means active low).
- R2: With `cfg_gated` = 1, every sampled byte is valid one clock later, whatever the level of `in_qual`.
- R3: With `cfg_port_sel` = 0, `out_valid`, `line_start` and `field_start` stay low whatever the inputs do.
- R4: In reference mode (`cfg_embedded` = 0), a horizontal edge raises `line_start` for exactly one cycle, after the third clock edge following the pin change (two synchronizer flops plus the output register). The edge is rising when `cfg_h_fall` = 0 and falling when `cfg_h_fall` = 1. The other edge gives no pulse.
- R5: In reference mode, `field_start` pulses for one cycle on vertical edges, with the same three-edge latency as R4. `cfg_v_edge` selects the edges: 0 means rising only, 1 means falling only, 2 or 3 means both.
- R6: In reference mode with `cfg_fid_level` = 0, every vertical edge, of either direction, loads `field_id` with the synchronized horizontal level. On a rising vertical edge that level is loaded as is. On a falling vertical edge it is loaded inverted.
- R7: In reference mode with `cfg_fid_level` = 1, `field_id` follows the vertical pin as a frame-sync odd/even level, with the three-edge latency of R4.
- R8: In embedded mode, a timing code is the qualified byte sequence all-ones, zero, zero, XY. Unqualified bytes neither advance nor break the sequence. When the XY byte has bit 4 = 0 (start of active video), `line_start` is high in the same cycle that `out_data` shows XY. Every code loads `field_id` from XY bit 6. The reference pins have no effect in this mode.
- R9: In embedded mode, `field_start` pulses with a code whose bit 5 (vertical blanking) is 0 when the previous code had bit 5 = 1.
- R10: In embedded mode, XY bits 3..0 are ignored. A preamble broken by any other qualified byte produces no code.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_sel | input | 1 | 1: this port feeds the scaler |
| cfg_embedded | input | 1 | 1: timing from embedded codes |
| cfg_h_fall | input | 1 | Horizontal trigger: 0 rising, 1 falling |
| cfg_v_edge | input | 2 | Vertical trigger: 0 rising, 1 falling, 2/3 both |
| cfg_qual_pol | input | 1 | Active level of the qualifier |
| cfg_gated | input | 1 | 1: gated-clock input, all bytes valid |
| cfg_fid_level | input | 1 | 1: field ID is the vertical pin level |
| in_data | input | DW | Byte-serial video data |
| in_qual | input | 1 | Data qualifier |
| in_href | input | 1 | Horizontal reference pin |
| in_vref | input | 1 | Vertical reference pin |
| out_data | output | DW | Registered video byte |
| out_valid | output | 1 | Byte in `out_data` is valid |
| line_start | output | 1 | One-cycle acquisition line-start marker |
| field_start | output | 1 | One-cycle acquisition field-start marker |
| field_id | output | 1 | Current field identifier |

## Verification
The two markers can fire in the same cycle. In reference mode this happens when both reference pins switch in the same cycle with triggers that match. The bench drives both pins together and checks that `line_start` and `field_start` first appear on the same sample, three edges later, each exactly once. In embedded mode, a start-of-active-video code that also ends vertical blanking must raise both markers together with the XY byte on `out_data`. The table walk contains such a code. Right after it comes a code that only starts a line, which must raise `line_start` alone.

// File: rtl/vport_pkg.sv
package vport_pkg;
   typedef enum logic [1:0] {
      VTRIG_RISE  = 2'd0,
      VTRIG_FALL  = 2'd1,
      VTRIG_BOTH  = 2'd2,
      VTRIG_BOTH2 = 2'd3
   } vtrig_e;

   // bit offsets of the timing-code flags, counted down from the MSB
   localparam int unsigned FLAG_F_OFS = 2;
   localparam int unsigned FLAG_V_OFS = 3;
   localparam int unsigned FLAG_H_OFS = 4;
endpackage

// File: rtl/vport_edge_sync.sv
module vport_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vport_edge_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[LAST];
   end

   assign level = chain[LAST];
   assign rise  = chain[LAST] & ~prev;
   assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/vport_code_det.sv
module vport_code_det
   import vport_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          qual,
   input  logic [DW-1:0] data,
   output logic          hit,
   output logic          f_bit,
   output logic          v_bit,
   output logic          eav,
   output logic          v_end
);
   localparam int unsigned F_POS = DW - 1 - FLAG_F_OFS + 1;
   localparam int unsigned V_POS = DW - 1 - FLAG_V_OFS + 1;
   localparam int unsigned H_POS = DW - 1 - FLAG_H_OFS + 1;

   logic [1:0] seen;
   logic       last_v;
   logic       all_one, all_zero;

   assign all_one  = &data;
   assign all_zero = ~|data;

   assign hit   = en & qual & (seen == 2'd3);
   assign f_bit = data[F_POS];
   assign v_bit = data[V_POS];
   assign eav   = data[H_POS];
   assign v_end = hit & ~v_bit & last_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 2'd0;
         last_v <= 1'b0;
      end else if (!en) begin
         seen   <= 2'd0;
         last_v <= 1'b0;
      end else if (qual) begin
         if (seen == 2'd3)                    seen <= 2'd0;
         else if (all_one)                    seen <= 2'd1;
         else if (all_zero && seen != 2'd0)   seen <= seen + 2'd1;
         else                                 seen <= 2'd0;
         if (hit) last_v <= v_bit;
      end
   end
endmodule

// File: rtl/vport_sync.sv
module vport_sync
   import vport_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_port_sel,
   input  logic          cfg_embedded,
   input  logic          cfg_h_fall,
   input  logic [1:0]    cfg_v_edge,
   input  logic          cfg_qual_pol,
   input  logic          cfg_gated,
   input  logic          cfg_fid_level,
   input  logic [DW-1:0] in_data,
   input  logic          in_qual,
   input  logic          in_href,
   input  logic          in_vref,
   output logic [DW-1:0] out_data,
   output logic          out_valid,
   output logic          line_start,
   output logic          field_start,
   output logic          field_id
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("vport_sync needs DW of at least 8");
      end
   endgenerate

   logic   h_lvl, h_rise, h_fall;
   logic   v_lvl, v_rise, v_fall;
   logic   qual;
   logic   h_hit, v_hit;
   logic   c_hit, c_f, c_v, c_eav, c_vend;
   vtrig_e v_mode;

   vport_edge_sync #(.STAGES(SYNC_STAGES)) u_href (
      .clk(clk), .rst_n(rst_n), .pin(in_href),
      .level(h_lvl), .rise(h_rise), .fall(h_fall)
   );

   vport_edge_sync #(.STAGES(SYNC_STAGES)) u_vref (
      .clk(clk), .rst_n(rst_n), .pin(in_vref),
      .level(v_lvl), .rise(v_rise), .fall(v_fall)
   );

   assign qual = cfg_gated | (in_qual == cfg_qual_pol);

   vport_code_det #(.DW(DW)) u_code (
      .clk(clk), .rst_n(rst_n), .en(cfg_embedded), .qual(qual), .data(in_data),
      .hit(c_hit), .f_bit(c_f), .v_bit(c_v), .eav(c_eav), .v_end(c_vend)
   );

   assign v_mode = vtrig_e'(cfg_v_edge);
   assign h_hit  = cfg_h_fall ? h_fall : h_rise;

   always_comb begin
      unique case (v_mode)
         VTRIG_RISE: v_hit = v_rise;
         VTRIG_FALL: v_hit = v_fall;
         default:    v_hit = v_rise | v_fall;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_valid   <= 1'b0;
         line_start  <= 1'b0;
         field_start <= 1'b0;
         field_id    <= 1'b0;
      end else begin
         out_data    <= in_data;
         out_valid   <= cfg_port_sel & qual;
         line_start  <= cfg_port_sel & (cfg_embedded ? (c_hit & ~c_eav) : h_hit);
         field_start <= cfg_port_sel & (cfg_embedded ? c_vend : v_hit);
         if (cfg_embedded) begin
            if (c_hit) field_id <= c_f;
         end else if (cfg_fid_level) begin
            field_id <= v_lvl;
         end else if (v_rise | v_fall) begin
            field_id <= h_lvl ^ v_fall;
         end
      end
   end
endmodule

// File: rtl/vport_sync_chk.sv
module vport_sync_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_port_sel,
   input logic          cfg_embedded,
   input logic          cfg_gated,
   input logic [DW-1:0] in_data,
   input logic [DW-1:0] out_data,
   input logic          out_valid,
   input logic          line_start,
   input logic          field_start
);
   assert_data_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_data == $past(in_data));

   assert_gated_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_port_sel && cfg_gated |=> out_valid);

   assert_unselected_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_port_sel |=> !out_valid && !line_start && !field_start);

   assert_line_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !line_start);

   assert_field_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> !field_start);

   assert_sav_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && $past(cfg_embedded) |-> out_valid && !out_data[DW-4]);
endmodule

bind vport_sync vport_sync_chk #(.DW(DW)) u_chk (.*);

// File: tb/vport_sync_bench.sv
`timescale 1ns/1ps
module vport_sync_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_port_sel = 1'b1, cfg_embedded = 1'b1, cfg_h_fall = 1'b0;
   logic [1:0]    cfg_v_edge = 2'd0;
   logic          cfg_qual_pol = 1'b1, cfg_gated = 1'b0, cfg_fid_level = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_qual = 1'b0, in_href = 1'b0, in_vref = 1'b0;
   logic [DW-1:0] out_data;
   logic          out_valid, line_start, field_start, field_id;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vport_sync u_vport_sync (
      .clk(clk), .rst_n(rst_n), .cfg_port_sel(cfg_port_sel), .cfg_embedded(cfg_embedded),
      .cfg_h_fall(cfg_h_fall), .cfg_v_edge(cfg_v_edge), .cfg_qual_pol(cfg_qual_pol),
      .cfg_gated(cfg_gated), .cfg_fid_level(cfg_fid_level), .in_data(in_data),
      .in_qual(in_qual), .in_href(in_href), .in_vref(in_vref), .out_data(out_data),
      .out_valid(out_valid), .line_start(line_start), .field_start(field_start),
      .field_id(field_id)
   );

   // {data, qual, exp_valid, exp_line, exp_field, exp_fid}; embedded mode (R8, R9, R10)
   localparam int NV = 21;
   localparam logic [12:0] VEC [0:NV-1] = '{
      {8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hB0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h89, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hC7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
      {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // samples six negedges after a pin change made at a negedge
   task automatic watch(output int nls, output int fls, output int nfs, output int ffs);
      nls = 0; fls = 0; nfs = 0; ffs = 0;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (line_start) begin nls++; if (fls == 0) fls = k; end
         if (field_start) begin nfs++; if (ffs == 0) ffs = k; end
      end
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int nls, fls, nfs, ffs;
      logic [12:0] e;
      in_qual = 1'b1;
      in_data = 8'hA5;
      repeat (2) @(negedge clk);
      // R11: outputs held at zero during reset
      check("R11 reset", {out_data, out_valid, line_start, field_start, field_id}, 32'h0);
      rst_n = 1'b1;

      // table walk, embedded mode
      e = VEC[0];
      in_data = e[12:5]; in_qual = e[4];
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         e = VEC[i];
         check($sformatf("R8/R9/R10 vec%0d", i),
               {e[3] ? out_data : 8'h00, out_valid, line_start, field_start, field_id},
               {e[3] ? e[12:5] : 8'h00, e[3], e[2], e[1], e[0]});
         if (i + 1 < NV) begin
            in_data = VEC[i+1][12:5];
            in_qual = VEC[i+1][4];
         end
      end

      // R8: reference pins ignored in embedded mode
      in_data = 8'h33;
      in_href = 1'b1; in_vref = 1'b1;
      watch(nls, fls, nfs, ffs);
      check("R8 pins ignored", {nls[7:0], nfs[7:0]}, 16'h0);

      // reference mode
      cfg_embedded = 1'b0;
      in_href = 1'b0; in_vref = 1'b0;
      do_reset();
      repeat (4) @(negedge clk);

      // R1: qualifier polarity
      cfg_qual_pol = 1'b0; in_qual = 1'b0; in_data = 8'h6C;
      @(negedge clk);
      check("R1 active-low qual valid", {out_valid, out_data}, {1'b1, 8'h6C});
      in_qual = 1'b1;
      @(negedge clk);
      check("R1 active-low qual idle", out_valid, 1'b0);
      cfg_qual_pol = 1'b1;
      @(negedge clk);
      check("R1 active-high qual valid", out_valid, 1'b1);

      // R2: gated clock
      cfg_gated = 1'b1; in_qual = 1'b0;
      @(negedge clk);
      check("R2 gated all valid", out_valid, 1'b1);
      cfg_gated = 1'b0;

      // R3: port not selected
      cfg_port_sel = 1'b0; in_qual = 1'b1;
      in_href = 1'b1;
      watch(nls, fls, nfs, ffs);
      check("R3 unselected valid", out_valid, 1'b0);
      check("R3 unselected marker", nls, 0);
      cfg_port_sel = 1'b1;
      in_href = 1'b0;
      watch(nls, fls, nfs, ffs);

      // R4: horizontal trigger
      cfg_h_fall = 1'b0;
      in_href = 1'b1; watch(nls, fls, nfs, ffs);
      check("R4 rising pulse", {nls[7:0], fls[7:0]}, {8'd1, 8'd3});
      in_href = 1'b0; watch(nls, fls, nfs, ffs);
      check("R4 falling ignored", nls, 0);
      cfg_h_fall = 1'b1;
      in_href = 1'b1; watch(nls, fls, nfs, ffs);
      check("R4 rising ignored", nls, 0);
      in_href = 1'b0; watch(nls, fls, nfs, ffs);
      check("R4 falling pulse", {nls[7:0], fls[7:0]}, {8'd1, 8'd3});

      // R5: vertical trigger
      for (int m = 0; m < 3; m++) begin
         cfg_v_edge = 2'(m);
         in_vref = 1'b1; watch(nls, fls, nfs, ffs);
         check($sformatf("R5 mode%0d rise", m), nfs, (m != 1) ? 1 : 0);
         in_vref = 1'b0; watch(nls, fls, nfs, ffs);
         check($sformatf("R5 mode%0d fall", m), nfs, (m != 0) ? 1 : 0);
      end

      // R4/R5: both markers in the same cycle
      cfg_h_fall = 1'b0; cfg_v_edge = 2'd0;
      in_href = 1'b1; in_vref = 1'b1;
      watch(nls, fls, nfs, ffs);
      check("R4/R5 coincident", {nls[7:0], fls[7:0], nfs[7:0], ffs[7:0]},
            {8'd1, 8'd3, 8'd1, 8'd3});

      // R6: field ID from vertical edge phase and horizontal level (href is 1)
      cfg_fid_level = 1'b0;
      in_vref = 1'b0; watch(nls, fls, nfs, ffs);
      check("R6 fall h1", field_id, 1'b0);
      in_vref = 1'b1; watch(nls, fls, nfs, ffs);
      check("R6 rise h1", field_id, 1'b1);
      in_href = 1'b0; watch(nls, fls, nfs, ffs);
      in_vref = 1'b0; watch(nls, fls, nfs, ffs);
      check("R6 fall h0", field_id, 1'b1);
      in_vref = 1'b1; watch(nls, fls, nfs, ffs);
      check("R6 rise h0", field_id, 1'b0);

      // R7: frame-sync level mode
      cfg_fid_level = 1'b1;
      watch(nls, fls, nfs, ffs);
      check("R7 level high", field_id, 1'b1);
      in_vref = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 latency", field_id, 1'b1);
      @(negedge clk);
      check("R7 level low", field_id, 1'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule